// File: doc/BRIEF.md
# Counter CSR Access Permission Checker

This block judges a read of one of the user-visible counter CSRs: the cycle counter, the real-time counter, the retired-instruction counter, the 29 programmable event counters, and, when the hart runs with 32-bit registers, the upper halves of all of them. For each request it weighs the current privilege level, the virtualization mode, three 32-bit counter-enable masks (one owned by each of the machine, hypervisor and supervisor levels) and three configuration inputs. Its verdict is one of four: allow the access, raise an illegal-instruction exception, raise a virtual-instruction fault, or report that the address is not a counter CSR at all.

The checks run in a fixed order. A missing counters extension fails first. The machine mask comes next, then the hypervisor mask under virtualization, then the supervisor mask for user-mode code. Only the supervisor stage has a result that depends on virtualization. Machine-mode code skips every mask. The verdict is registered and appears in the cycle after the request strobe. When no strobe arrives, all outputs fall back to zero.

Top module: `ctr_access_gate`

## Requirements
- R1: With `cfg_ctr_en` low, every counter address raises `rsp_illegal`, whatever the privilege, mode and masks.
- R2: Addresses 0xC00 to 0xC1F select enable bit (address - 0xC00). Bit 0 is the cycle counter, bit 1 the time counter, bit 2 the retired-instruction counter and bit N event counter N.
- R3: Addresses 0xC80 to 0xC9F select enable bit (address - 0xC80), but only while `cfg_rv32` is high. With `cfg_rv32` low they are not counter addresses, so `rsp_not_ctr` is set.
- R4: Below machine level (`priv_lvl` 0 = user, 1 = supervisor; 3 = machine), a clear selected machine-mask bit raises `rsp_illegal`. This holds even when the hypervisor and supervisor bits are also clear.
- R5: Below machine level, with the machine bit set, `virt_on` high and the selected hypervisor-mask bit clear, the access raises `rsp_vfault`.
- R6: At user level, with the earlier checks passed, `cfg_has_s` high and the selected supervisor-mask bit clear, the access raises `rsp_vfault` if `virt_on` is high and `rsp_illegal` otherwise. With `cfg_has_s` low the supervisor mask has no effect.
- R7: At machine level with `cfg_ctr_en` high, a counter access raises `rsp_allow` regardless of all three masks and `virt_on`.
- R8: An address outside both counter ranges gives `rsp_not_ctr` high, with allow and both exception outputs low.
- R9: Outputs update on the clock edge that samples `req_valid` high. Then `rsp_valid` is high and exactly one of allow, illegal, vfault and not_ctr is high. After an edge with `req_valid` low, all five outputs are low.
- R10: While `rst` is high, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| csr_addr | input | 12 | CSR address of the access |
| priv_lvl | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| virt_on | input | 1 | Virtualization mode active |
| m_cnt_en | input | 32 | Machine-level counter-enable mask |
| h_cnt_en | input | 32 | Hypervisor-level counter-enable mask |
| s_cnt_en | input | 32 | Supervisor-level counter-enable mask |
| cfg_ctr_en | input | 1 | Counters extension present |
| cfg_has_s | input | 1 | Supervisor mode present |
| cfg_rv32 | input | 1 | 32-bit operation; enables the upper-half addresses |
| rsp_valid | output | 1 | Verdict valid (one cycle after strobe) |
| rsp_allow | output | 1 | Access permitted |
| rsp_illegal | output | 1 | Illegal-instruction exception |
| rsp_vfault | output | 1 | Virtual-instruction fault |
| rsp_not_ctr | output | 1 | Address is not a counter CSR |

## Verification
The hardest verdict to reach is a user-mode supervisor-mask fault under virtualization. It needs the selected bit set in both the machine and hypervisor masks and clear in the supervisor mask, all for the one counter being addressed. Uniform random masks give that combination for only about one access in eight. So the sweep of every counter address against every privilege and mode pairing draws fresh masks for each access. A set of directed accesses then forces each stage of the check order to be the deciding one, including the case where all three bits are clear and the machine stage must win.

// File: rtl/ctr_gate_pkg.sv
package ctr_gate_pkg;

    parameter int          CSR_AW_DEF  = 12;
    parameter int          NUM_CTR_DEF = 32;
    parameter logic [11:0] LO_BASE_DEF = 12'hC00;
    parameter logic [11:0] HI_BASE_DEF = 12'hC80;

    typedef enum logic [1:0] {
        PRIV_U    = 2'd0,
        PRIV_S    = 2'd1,
        PRIV_RSVD = 2'd2,
        PRIV_M    = 2'd3
    } priv_e;

    typedef enum logic [1:0] {
        VERDICT_ALLOW   = 2'd0,
        VERDICT_ILLEGAL = 2'd1,
        VERDICT_VFAULT  = 2'd2,
        VERDICT_NOTCTR  = 2'd3
    } verdict_e;

    typedef struct packed {
        logic valid;
        logic allow;
        logic illegal;
        logic vfault;
        logic not_ctr;
    } rsp_t;

    function automatic rsp_t verdict_to_rsp(verdict_e v);
        rsp_t r;
        r         = '0;
        r.valid   = 1'b1;
        r.allow   = (v == VERDICT_ALLOW);
        r.illegal = (v == VERDICT_ILLEGAL);
        r.vfault  = (v == VERDICT_VFAULT);
        r.not_ctr = (v == VERDICT_NOTCTR);
        return r;
    endfunction

    function automatic logic below_machine(priv_e p);
        return p != PRIV_M;
    endfunction

endpackage

// File: rtl/ctr_addr_decode.sv
module ctr_addr_decode #(
    parameter int              ADDR_W  = 12,
    parameter int              NUM_CTR = 32,
    parameter logic [ADDR_W-1:0] LO_BASE = 12'hC00,
    parameter logic [ADDR_W-1:0] HI_BASE = 12'hC80
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic               rv32,
    output logic [NUM_CTR-1:0] sel,
    output logic               hit
);
    logic [NUM_CTR-1:0] sel_lo;
    logic [NUM_CTR-1:0] sel_hi;

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_slot
        assign sel_lo[i] = (addr == LO_BASE + ADDR_W'(i));
        assign sel_hi[i] = rv32 && (addr == HI_BASE + ADDR_W'(i));
    end

    assign sel = sel_lo | sel_hi;
    assign hit = |sel;
endmodule

// File: rtl/ctr_perm_eval.sv
module ctr_perm_eval
    import ctr_gate_pkg::*;
#(
    parameter int NUM_CTR = 32
) (
    input  logic [NUM_CTR-1:0] sel,
    input  logic               hit,
    input  priv_e              priv,
    input  logic               virt,
    input  logic [NUM_CTR-1:0] m_en,
    input  logic [NUM_CTR-1:0] h_en,
    input  logic [NUM_CTR-1:0] s_en,
    input  logic               ext_on,
    input  logic               has_s,
    output verdict_e           verdict
);
    logic m_ok, h_ok, s_ok;

    assign m_ok = |(sel & m_en);
    assign h_ok = |(sel & h_en);
    assign s_ok = |(sel & s_en);

    always_comb begin
        if (!hit)
            verdict = VERDICT_NOTCTR;
        else if (!ext_on)
            verdict = VERDICT_ILLEGAL;
        else if (!below_machine(priv))
            verdict = VERDICT_ALLOW;
        else if (!m_ok)
            verdict = VERDICT_ILLEGAL;
        else if (virt && !h_ok)
            verdict = VERDICT_VFAULT;
        else if (has_s && (priv == PRIV_U) && !s_ok)
            verdict = virt ? VERDICT_VFAULT : VERDICT_ILLEGAL;
        else
            verdict = VERDICT_ALLOW;
    end
endmodule

// File: rtl/ctr_rsp_reg.sv
module ctr_rsp_reg
    import ctr_gate_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     req,
    input  verdict_e verdict,
    output rsp_t     rsp_q
);
    always_ff @(posedge clk) begin
        if (rst)
            rsp_q <= '0;
        else if (req)
            rsp_q <= verdict_to_rsp(verdict);
        else
            rsp_q <= '0;
    end
endmodule

// File: rtl/ctr_access_gate.sv
module ctr_access_gate
    import ctr_gate_pkg::*;
#(
    parameter int                ADDR_W  = CSR_AW_DEF,
    parameter int                NUM_CTR = NUM_CTR_DEF,
    parameter logic [ADDR_W-1:0] LO_BASE = LO_BASE_DEF,
    parameter logic [ADDR_W-1:0] HI_BASE = HI_BASE_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  csr_addr,
    input  logic [1:0]         priv_lvl,
    input  logic               virt_on,
    input  logic [NUM_CTR-1:0] m_cnt_en,
    input  logic [NUM_CTR-1:0] h_cnt_en,
    input  logic [NUM_CTR-1:0] s_cnt_en,
    input  logic               cfg_ctr_en,
    input  logic               cfg_has_s,
    input  logic               cfg_rv32,
    output logic               rsp_valid,
    output logic               rsp_allow,
    output logic               rsp_illegal,
    output logic               rsp_vfault,
    output logic               rsp_not_ctr
);
    logic [NUM_CTR-1:0] slot_sel;
    logic               slot_hit;
    verdict_e           verdict;
    rsp_t               rsp_q;

    ctr_addr_decode #(
        .ADDR_W (ADDR_W),
        .NUM_CTR(NUM_CTR),
        .LO_BASE(LO_BASE),
        .HI_BASE(HI_BASE)
    ) decode_i (
        .addr(csr_addr),
        .rv32(cfg_rv32),
        .sel (slot_sel),
        .hit (slot_hit)
    );

    ctr_perm_eval #(
        .NUM_CTR(NUM_CTR)
    ) eval_i (
        .sel    (slot_sel),
        .hit    (slot_hit),
        .priv   (priv_e'(priv_lvl)),
        .virt   (virt_on),
        .m_en   (m_cnt_en),
        .h_en   (h_cnt_en),
        .s_en   (s_cnt_en),
        .ext_on (cfg_ctr_en),
        .has_s  (cfg_has_s),
        .verdict(verdict)
    );

    ctr_rsp_reg rsp_i (
        .clk    (clk),
        .rst    (rst),
        .req    (req_valid),
        .verdict(verdict),
        .rsp_q  (rsp_q)
    );

    assign rsp_valid   = rsp_q.valid;
    assign rsp_allow   = rsp_q.allow;
    assign rsp_illegal = rsp_q.illegal;
    assign rsp_vfault  = rsp_q.vfault;
    assign rsp_not_ctr = rsp_q.not_ctr;
endmodule

// File: rtl/ctr_access_gate_chk.sv
module ctr_access_gate_chk #(
    parameter int                ADDR_W  = 12,
    parameter int                NUM_CTR = 32,
    parameter logic [ADDR_W-1:0] LO_BASE = 12'hC00,
    parameter logic [ADDR_W-1:0] HI_BASE = 12'hC80
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic [ADDR_W-1:0]  csr_addr,
    input logic [1:0]         priv_lvl,
    input logic               virt_on,
    input logic [NUM_CTR-1:0] m_cnt_en,
    input logic [NUM_CTR-1:0] h_cnt_en,
    input logic [NUM_CTR-1:0] s_cnt_en,
    input logic               cfg_ctr_en,
    input logic               cfg_has_s,
    input logic               cfg_rv32,
    input logic               rsp_valid,
    input logic               rsp_allow,
    input logic               rsp_illegal,
    input logic               rsp_vfault,
    input logic               rsp_not_ctr
);
    logic in_lo, in_hi;
    assign in_lo = (csr_addr >= LO_BASE) && (csr_addr < LO_BASE + ADDR_W'(NUM_CTR));
    assign in_hi = (csr_addr >= HI_BASE) && (csr_addr < HI_BASE + ADDR_W'(NUM_CTR));

    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid && ($countones({rsp_allow, rsp_illegal, rsp_vfault, rsp_not_ctr}) == 1)); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid && !rsp_allow && !rsp_illegal && !rsp_vfault && !rsp_not_ctr); // R9

    AST_EXT_OFF: assert property (@(posedge clk) disable iff (rst)
        req_valid && !cfg_ctr_en && in_lo |=> rsp_illegal); // R1

    AST_MACH_FIRST: assert property (@(posedge clk) disable iff (rst)
        req_valid && cfg_ctr_en && in_lo && (priv_lvl != 2'd3) && (m_cnt_en == '0) |=> rsp_illegal); // R4

    AST_HYP_FAULT: assert property (@(posedge clk) disable iff (rst)
        req_valid && cfg_ctr_en && in_lo && (priv_lvl != 2'd3) && virt_on
        && (m_cnt_en == '1) && (h_cnt_en == '0) |=> rsp_vfault); // R5

    AST_SUP_VIRT: assert property (@(posedge clk) disable iff (rst)
        req_valid && cfg_ctr_en && cfg_has_s && in_lo && (priv_lvl == 2'd0) && virt_on
        && (m_cnt_en == '1) && (h_cnt_en == '1) && (s_cnt_en == '0) |=> rsp_vfault); // R6

    AST_MACH_ALLOW: assert property (@(posedge clk) disable iff (rst)
        req_valid && cfg_ctr_en && in_lo && (priv_lvl == 2'd3) |=> rsp_allow); // R7

    AST_NOT_CTR: assert property (@(posedge clk) disable iff (rst)
        req_valid && !in_lo && !in_hi |=> rsp_not_ctr); // R8

    AST_HI_RV64: assert property (@(posedge clk) disable iff (rst)
        req_valid && !cfg_rv32 && in_hi && !in_lo |=> rsp_not_ctr); // R3
endmodule

bind ctr_access_gate ctr_access_gate_chk #(
    .ADDR_W (ADDR_W),
    .NUM_CTR(NUM_CTR),
    .LO_BASE(LO_BASE),
    .HI_BASE(HI_BASE)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .csr_addr   (csr_addr),
    .priv_lvl   (priv_lvl),
    .virt_on    (virt_on),
    .m_cnt_en   (m_cnt_en),
    .h_cnt_en   (h_cnt_en),
    .s_cnt_en   (s_cnt_en),
    .cfg_ctr_en (cfg_ctr_en),
    .cfg_has_s  (cfg_has_s),
    .cfg_rv32   (cfg_rv32),
    .rsp_valid  (rsp_valid),
    .rsp_allow  (rsp_allow),
    .rsp_illegal(rsp_illegal),
    .rsp_vfault (rsp_vfault),
    .rsp_not_ctr(rsp_not_ctr)
);

// File: tb/ctr_access_gate_tb_top.sv
module ctr_access_gate_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [1:0]  priv_lvl = '0;
    logic        virt_on = 1'b0;
    logic [31:0] m_cnt_en = '0, h_cnt_en = '0, s_cnt_en = '0;
    logic        cfg_ctr_en = 1'b1, cfg_has_s = 1'b1, cfg_rv32 = 1'b1;
    logic        rsp_valid, rsp_allow, rsp_illegal, rsp_vfault, rsp_not_ctr;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    ctr_access_gate dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .csr_addr(csr_addr),
        .priv_lvl(priv_lvl), .virt_on(virt_on), .m_cnt_en(m_cnt_en),
        .h_cnt_en(h_cnt_en), .s_cnt_en(s_cnt_en), .cfg_ctr_en(cfg_ctr_en),
        .cfg_has_s(cfg_has_s), .cfg_rv32(cfg_rv32), .rsp_valid(rsp_valid),
        .rsp_allow(rsp_allow), .rsp_illegal(rsp_illegal), .rsp_vfault(rsp_vfault),
        .rsp_not_ctr(rsp_not_ctr)
    );

    // {valid, allow, illegal, vfault, not_ctr}
    function automatic logic [4:0] model(logic [11:0] a, logic [1:0] p, logic v,
                                         logic [31:0] me, logic [31:0] he, logic [31:0] se,
                                         logic ext, logic s, logic r32);
        int  idx;
        bit  hit;
        hit = 0; idx = 0;
        if (a >= 12'hC00 && a <= 12'hC1F) begin hit = 1; idx = int'(a - 12'hC00); end
        else if (r32 && a >= 12'hC80 && a <= 12'hC9F) begin hit = 1; idx = int'(a - 12'hC80); end
        if (!hit)                     return 5'b10001;
        if (!ext)                     return 5'b10100;
        if (p == 2'd3)                return 5'b11000;
        if (!me[idx])                 return 5'b10100;
        if (v && !he[idx])            return 5'b10010;
        if (s && p == 2'd0 && !se[idx]) return v ? 5'b10010 : 5'b10100;
        return 5'b11000;
    endfunction

    function automatic string tag_of(logic [11:0] a, logic [1:0] p, logic v,
                                     logic [31:0] me, logic [31:0] he,
                                     logic ext, logic r32);
        int idx;
        idx = int'(a[4:0]);
        if (a[11:8] != 4'hC || a[6:5] != 2'b00) return "R8";
        if (a[7] && !r32)                       return "R3";
        if (!ext)                               return "R1";
        if (p == 2'd3)                          return "R7";
        if (!me[idx])                           return "R4";
        if (v && !he[idx])                      return "R5";
        return a[7] ? "R3" : "R6";
    endfunction

    task automatic compare(string tag, logic [4:0] exp);
        logic [4:0] act;
        act = {rsp_valid, rsp_allow, rsp_illegal, rsp_vfault, rsp_not_ctr};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s addr=%h priv=%0d virt=%0b actual=%b expected=%b",
                     tag, csr_addr, priv_lvl, virt_on, act, exp);
        end
    endtask

    task automatic access(logic [11:0] a, logic [1:0] p, logic v,
                          logic [31:0] me, logic [31:0] he, logic [31:0] se, bit idle_chk);
        @(negedge clk);
        req_valid = 1'b1; csr_addr = a; priv_lvl = p; virt_on = v;
        m_cnt_en = me; h_cnt_en = he; s_cnt_en = se;
        @(negedge clk);
        compare(tag_of(a, p, v, me, he, cfg_ctr_en, cfg_rv32),
                model(a, p, v, me, he, se, cfg_ctr_en, cfg_has_s, cfg_rv32));
        req_valid = 1'b0;
        if (idle_chk) begin
            @(negedge clk);
            compare("R9", 5'b00000);
        end
    endtask

    task automatic sweep();
        logic [1:0] privs [3];
        privs[0] = 2'd0; privs[1] = 2'd1; privs[2] = 2'd3;
        for (int blk = 0; blk < 2; blk++) begin
            for (int k = 0; k < 32; k++) begin
                for (int pi = 0; pi < 3; pi++) begin
                    for (int vv = 0; vv < 2; vv++) begin
                        access((blk == 0 ? 12'hC00 : 12'hC80) + 12'(k), privs[pi], vv[0],
                               $urandom, $urandom, $urandom, (k % 8) == 0);
                    end
                end
            end
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R10: reset state
        repeat (2) @(negedge clk);
        compare("R10", 5'b00000);
        req_valid = 1'b1; csr_addr = 12'hC00; priv_lvl = 2'd3;
        @(negedge clk);
        compare("R10", 5'b00000);
        req_valid = 1'b0;
        rst = 1'b0;

        // Directed: R2 bit mapping, only the selected bit matters
        cfg_ctr_en = 1; cfg_has_s = 1; cfg_rv32 = 1;
        access(12'hC01, 2'd0, 0, 32'h0000_0002, 32'h0, 32'h0000_0002, 1); // R2 allow
        access(12'hC01, 2'd0, 0, 32'hFFFF_FFFD, '1, '1, 0);               // R2 illegal
        access(12'hC1F, 2'd1, 0, 32'h8000_0000, 32'h0, 32'h0, 0);         // R2 allow
        access(12'hC9F, 2'd1, 0, 32'h8000_0000, 32'h0, 32'h0, 0);         // R3 rv32 upper
        // R4 precedence over later stages
        access(12'hC02, 2'd0, 1, 32'h0, 32'h0, 32'h0, 0);
        // R5
        access(12'hC03, 2'd1, 1, '1, 32'h0, '1, 0);
        // R6 both modes and no-S case
        access(12'hC04, 2'd0, 1, '1, '1, 32'h0, 0);
        access(12'hC04, 2'd0, 0, '1, '1, 32'h0, 0);
        cfg_has_s = 0;
        access(12'hC04, 2'd0, 0, '1, '1, 32'h0, 0);                      // R6 no effect
        access(12'hC04, 2'd0, 1, '1, '1, 32'h0, 0);
        cfg_has_s = 1;
        // R7
        access(12'hC05, 2'd3, 1, 32'h0, 32'h0, 32'h0, 0);
        // R1
        cfg_ctr_en = 0;
        access(12'hC00, 2'd3, 0, '1, '1, '1, 0);
        access(12'hC85, 2'd0, 1, '1, '1, '1, 0);
        access(12'h300, 2'd3, 0, '1, '1, '1, 0);                         // R8 with ext off
        cfg_ctr_en = 1;
        // R3 upper half ignored outside rv32
        cfg_rv32 = 0;
        access(12'hC80, 2'd3, 0, '1, '1, '1, 0);
        access(12'hC9F, 2'd0, 0, '1, '1, '1, 0);
        cfg_rv32 = 1;
        // R8 neighbours of the ranges
        access(12'hC20, 2'd3, 0, '1, '1, '1, 0);
        access(12'hC7F, 2'd3, 0, '1, '1, '1, 0);
        access(12'hCA0, 2'd0, 0, '1, '1, '1, 0);
        access(12'hBFF, 2'd1, 1, '1, '1, '1, 1);

        // Random sweeps over configuration passes
        cfg_ctr_en = 1; cfg_has_s = 1; cfg_rv32 = 1; sweep();
        cfg_ctr_en = 1; cfg_has_s = 1; cfg_rv32 = 0; sweep();
        cfg_ctr_en = 1; cfg_has_s = 0; cfg_rv32 = 1; sweep();
        cfg_ctr_en = 0; cfg_has_s = 1; cfg_rv32 = 1; sweep();

        // Random non-counter addresses, R8
        cfg_ctr_en = 1;
        for (int n = 0; n < 200; n++) begin
            logic [11:0] a;
            a = 12'($urandom);
            access(a, 2'($urandom), 1'($urandom), $urandom, $urandom, $urandom, 0);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule